// File: doc/BRIEF.md
# Word-Streaming Memory Loader with Running CRC

This block sits behind a 16-bit synchronous register port and lets a host put 32-bit words into an on-chip memory one at a time. The host sets a word-aligned target address once, through two 16-bit halves. It then streams data, each word also split into two 16-bit halves. For each word it issues a commit command. Each commit writes the assembled word to the memory port, and the target pointer steps to the next word on its own.

Each committed word is also folded into a running CRC-16. The CRC uses polynomial 0x1021, processed most significant bit first, with no reflection and no final inversion. The four bytes of the word enter the CRC highest byte first. After the last word, the host reads the CRC back through the same register port and compares it with its own value to confirm that the image arrived intact. A busy flag covers the cycles in which the CRC is still absorbing a word, and the block ignores commands issued during that window.

Top module: `mbx_loader`

## Requirements
- R1: After reset, memWe is 0, the busy flag is 0, the CRC reads 0x0000 and the word pointer is 0.
- R2: Registers sit at REG_BASE (default 0x0200) plus an offset: +0 command/status, +1 CRC readback, +2 pointer bits 31:16, +3 pointer bits 15:2, +4 data bits 31:16, +5 data bits 15:0. A write to any other address has no effect.
- R3: A command write with bit 15 (execute) and bit 14 (write) both set drives memWe high for exactly one cycle, on the cycle after the register write. In that cycle memAddr is the current pointer and memData is {data high, data low}.
- R4: Bits 1:0 of the pointer-low register are discarded, so memAddr[1:0] is always 0.
- R5: Each commit advances the pointer by 4. A write to either pointer register reloads that half of the pointer.
- R6: A command with execute set but write clear produces no memory write, leaves the CRC unchanged and leaves the pointer unchanged.
- R7: The CRC absorbs the committed word one byte per clock, bits 31:24 first. The updated value is readable at offset +1 from the fifth cycle after the commit onward.
- R8: A command write with bit 12 set clears the CRC to 0x0000. When bit 12 is combined with execute and write, the clear applies before the new word is absorbed.
- R9: A read of offset +0 returns the busy flag in bit 8 and zero in every other bit. The busy flag is high for exactly four cycles after each commit.
- R10: A command write that arrives while the busy flag is high is discarded completely.
- R11: Read data is registered: regRdData shows the selected value in the cycle after regRd. Reads of the pointer registers, the data registers and unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 16 | Register address |
| regWrData | input | 16 | Register write data |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regRdData | output | 16 | Registered read data |
| memAddr | output | 32 | Memory byte address, word aligned |
| memData | output | 32 | Memory write data |
| memWe | output | 1 | Memory write enable, one cycle per commit |

## Verification
The assertions assume that the host issues at most one register access per cycle. Because of this, a commit never coincides with a pointer reload, and the pointer-step check can compare against the value from the previous cycle. They also assume that reset is asserted long enough for every register to settle. The bench drives the host port from a single task at the falling edge, with one strobe per call. It issues a back-to-back command only in the busy-window scenario, where discarding that command is the behaviour under test.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int REG_W   = 16;
  localparam int ADDR_W  = 32;
  localparam int WORD_W  = 32;
  localparam int CRC_W   = 16;
  localparam int BYTES_W = WORD_W / 8;
  localparam int STEP_W  = $clog2(BYTES_W);
  localparam int ALIGN_W = $clog2(BYTES_W);

  localparam int BIT_EXEC  = 15;
  localparam int BIT_WRITE = 14;
  localparam int BIT_CLR   = 12;
  localparam int BIT_BUSY  = 8;

  typedef enum logic [1:0] {RD_ZERO, RD_STATUS, RD_CRC} rdSel_t;

  typedef struct packed {
    logic              commit;
    logic              crcClear;
    logic              crcStep;
    logic [STEP_W-1:0] byteSel;
    logic              ldAddrHi;
    logic              ldAddrLo;
    logic              ldDataHi;
    logic              ldDataLo;
    logic              rdEn;
    rdSel_t            rdSel;
  } mbxStrb_t;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter logic [REG_W-1:0] REG_BASE = 16'h0200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] regAddr,
  input  logic [REG_W-1:0] regWrData,
  input  logic             regWr,
  input  logic             regRd,
  output mbxStrb_t         strb,
  output logic             busy
);
  localparam int NUM_REGS = 6;

  typedef enum logic {ST_IDLE, ST_FEED} state_t;

  state_t            stateQ;
  logic [STEP_W-1:0] stepCnt;
  logic [REG_W-1:0]  offs;
  logic              hit;
  logic [NUM_REGS-1:0] sel;
  logic              cmdWr;

  assign offs = regAddr - REG_BASE;
  assign hit  = (regAddr >= REG_BASE) && (offs < REG_W'(NUM_REGS));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign sel[g] = hit && (offs == REG_W'(g));
  end

  assign busy  = (stateQ == ST_FEED);
  assign cmdWr = regWr && sel[0] && !busy;

  always_comb begin
    strb          = '0;
    strb.rdSel    = RD_ZERO;
    strb.commit   = cmdWr && regWrData[BIT_EXEC] && regWrData[BIT_WRITE];
    strb.crcClear = cmdWr && regWrData[BIT_CLR];
    strb.crcStep  = busy;
    strb.byteSel  = stepCnt;
    strb.ldAddrHi = regWr && sel[2];
    strb.ldAddrLo = regWr && sel[3];
    strb.ldDataHi = regWr && sel[4];
    strb.ldDataLo = regWr && sel[5];
    strb.rdEn     = regRd;
    if (sel[0])      strb.rdSel = RD_STATUS;
    else if (sel[1]) strb.rdSel = RD_CRC;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: if (strb.commit) begin
          stateQ  <= ST_FEED;
          stepCnt <= '0;
        end
        ST_FEED: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == STEP_W'(BYTES_W - 1)) stateQ <= ST_IDLE;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  // R9: a commit opens the busy window starting from the first byte
  a_r9_busy_on_commit: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> (busy && stepCnt == '0));
  // R9: the busy window closes only after the last byte step
  a_r9_busy_len: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(stepCnt) == STEP_W'(BYTES_W - 1)));
endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbxStrb_t          strb,
  input  logic              busy,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memData,
  output logic              memWe
);
  logic [ADDR_W-1:ALIGN_W] ptrQ;
  logic [REG_W-1:0]        dataHi, dataLo;
  logic [WORD_W-1:0]       wordQ;
  logic [CRC_W-1:0]        crcQ;
  logic [7:0]              curByte;

  function automatic logic [CRC_W-1:0] crcByte(input logic [CRC_W-1:0] c,
                                               input logic [7:0] b);
    logic [CRC_W-1:0] r;
    r = c ^ {b, {(CRC_W-8){1'b0}}};
    for (int i = 0; i < 8; i++)
      r = r[CRC_W-1] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    return r;
  endfunction

  assign curByte = wordQ[WORD_W-1 - 8*strb.byteSel -: 8];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ   <= '0;
      dataHi <= '0;
      dataLo <= '0;
      wordQ  <= '0;
      memAddr <= '0;
      memData <= '0;
      memWe  <= 1'b0;
    end else begin
      memWe <= strb.commit;
      if (strb.ldAddrHi) ptrQ[ADDR_W-1:REG_W] <= regWrData;
      if (strb.ldAddrLo) ptrQ[REG_W-1:ALIGN_W] <= regWrData[REG_W-1:ALIGN_W];
      if (strb.ldDataHi) dataHi <= regWrData;
      if (strb.ldDataLo) dataLo <= regWrData;
      if (strb.commit) begin
        memAddr <= {ptrQ, {ALIGN_W{1'b0}}};
        memData <= {dataHi, dataLo};
        wordQ   <= {dataHi, dataLo};
        ptrQ    <= ptrQ + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              crcQ <= '0;
    else if (strb.crcClear) crcQ <= '0;
    else if (strb.crcStep)  crcQ <= crcByte(crcQ, curByte);
  end

  always_ff @(posedge clk) begin
    if (!rstN) regRdData <= '0;
    else if (strb.rdEn) begin
      case (strb.rdSel)
        RD_STATUS: regRdData <= REG_W'(busy) << BIT_BUSY;
        RD_CRC:    regRdData <= crcQ;
        default:   regRdData <= '0;
      endcase
    end
  end

  // R3: the memory strobe is a single-cycle pulse
  a_r3_we_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);
  // R4: the memory address is always word aligned
  a_r4_aligned: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr[ALIGN_W-1:0] == '0));
  // R5: each commit steps the pointer by one word
  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> (ptrQ == $past(ptrQ) + 1'b1));
  // R7: the CRC changes only on a clear or a byte step
  a_r7_crc_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.crcClear || strb.crcStep) |=> $stable(crcQ));
endmodule

// File: rtl/mbx_loader.sv
module mbx_loader
  import mbx_pkg::*;
#(
  parameter logic [15:0] REG_BASE = 16'h0200,
  parameter logic [15:0] CRC_POLY = 16'h1021
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] regAddr,
  input  logic [15:0] regWrData,
  input  logic        regWr,
  input  logic        regRd,
  output logic [15:0] regRdData,
  output logic [31:0] memAddr,
  output logic [31:0] memData,
  output logic        memWe
);
  mbxStrb_t strb;
  logic     busy;

  mbx_ctrl #(.REG_BASE(REG_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWr(regWr), .regRd(regRd), .strb(strb), .busy(busy)
  );

  mbx_datapath #(.CRC_POLY(CRC_POLY)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .regWrData(regWrData),
    .regRdData(regRdData), .memAddr(memAddr), .memData(memData), .memWe(memWe)
  );

  // R10: a commit cannot start while a previous word is still being absorbed
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !memWe);
endmodule

// File: tb/mbx_loader_tb.sv
module mbx_loader_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] regAddr, regWrData, regRdData;
  logic        regWr, regRd, memWe;
  logic [31:0] memAddr, memData;
  int checks = 0, fails = 0;
  logic [15:0] model;

  localparam logic [15:0] A_CMD = 16'h0200, A_CRC = 16'h0201, A_AHI = 16'h0202,
                          A_ALO = 16'h0203, A_DHI = 16'h0204, A_DLO = 16'h0205;

  always #2 clk = ~clk;

  mbx_loader u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWr(regWr), .regRd(regRd), .regRdData(regRdData),
    .memAddr(memAddr), .memData(memData), .memWe(memWe)
  );

  function automatic logic [15:0] tbCrcWord(input logic [15:0] c, input logic [31:0] w);
    logic [15:0] r = c;
    for (int i = 31; i >= 0; i--) begin
      logic fb = r[15] ^ w[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wrReg(input logic [15:0] a, input logic [15:0] d);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [15:0] a, output logic [15:0] d);
    regAddr = a; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
    d = regRdData;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic putWord(input logic [31:0] w);
    wrReg(A_DHI, w[31:16]);
    wrReg(A_DLO, w[15:0]);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 memWe", memWe, 0);
    rdReg(A_CMD, v); check("R1 busy", v, 16'h0000);
    rdReg(A_CRC, v); check("R1 crc", v, 16'h0000);
    putWord(32'h0BAD_F00D);
    wrReg(A_CMD, 16'hC000);
    check("R1 ptr zero", memAddr, 32'h0);
    model = tbCrcWord(16'h0, 32'h0BAD_F00D);
    settle();
  endtask

  task automatic t_single();
    logic [15:0] v;
    wrReg(A_AHI, 16'h1234);
    wrReg(A_ALO, 16'h5679);
    putWord(32'hDEAD_BEEF);
    wrReg(A_CMD, 16'hD000);
    check("R3 memWe", memWe, 1);
    check("R4 memAddr", memAddr, 32'h1234_5678);
    check("R3 memData", memData, 32'hDEAD_BEEF);
    for (int k = 0; k < 5; k++) begin
      rdReg(A_CMD, v);
      check("R9 busy window", v, (k < 4) ? 16'h0100 : 16'h0000);
      if (k == 0) check("R3 memWe single", memWe, 0);
    end
    model = tbCrcWord(16'h0, 32'hDEAD_BEEF);
    rdReg(A_CRC, v); check("R7 crc one word", v, model);
    rdReg(A_CRC, v); check("R8 clear before feed", v, tbCrcWord(16'h0, 32'hDEAD_BEEF));
  endtask

  task automatic t_stream();
    logic [15:0] v;
    logic [31:0] words [3] = '{32'h0102_0304, 32'hFFFF_0000, 32'h8000_0001};
    wrReg(A_CMD, 16'h1000);
    wrReg(A_AHI, 16'h4000);
    wrReg(A_ALO, 16'h0000);
    model = 16'h0;
    for (int k = 0; k < 3; k++) begin
      putWord(words[k]);
      wrReg(A_CMD, 16'hC000);
      check("R5 stream addr", memAddr, 32'h4000_0000 + 32'(4 * k));
      check("R3 stream data", memData, words[k]);
      model = tbCrcWord(model, words[k]);
      settle();
    end
    rdReg(A_CRC, v); check("R7 crc stream", v, model);
    wrReg(A_ALO, 16'h0100);
    putWord(32'h5555_AAAA);
    wrReg(A_CMD, 16'hC000);
    check("R5 reload lo", memAddr, 32'h4000_0100);
    model = tbCrcWord(model, 32'h5555_AAAA);
    settle();
  endtask

  task automatic t_clear();
    logic [15:0] v;
    rdReg(A_CRC, v); check("R7 crc before clear", v, model);
    wrReg(A_CMD, 16'h1000);
    rdReg(A_CRC, v); check("R8 crc cleared", v, 16'h0000);
  endtask

  task automatic t_execOnly();
    logic [15:0] v;
    wrReg(A_ALO, 16'h0200);
    putWord(32'h1111_2222);
    wrReg(A_CMD, 16'h8000);
    check("R6 no memWe", memWe, 0);
    settle();
    rdReg(A_CRC, v); check("R6 crc unchanged", v, 16'h0000);
    wrReg(A_CMD, 16'hC000);
    check("R6 ptr unchanged", memAddr, 32'h4000_0200);
    settle();
  endtask

  task automatic t_busyIgnore();
    logic [15:0] v;
    wrReg(A_CMD, 16'h1000);
    wrReg(A_ALO, 16'h0300);
    putWord(32'hCAFE_0001);
    wrReg(A_CMD, 16'hC000);
    wrReg(A_CMD, 16'hD000);
    check("R10 ignored commit", memWe, 0);
    settle();
    rdReg(A_CRC, v); check("R10 crc one word", v, tbCrcWord(16'h0, 32'hCAFE_0001));
    wrReg(A_CMD, 16'hC000);
    check("R10 ptr advanced once", memAddr, 32'h4000_0304);
    settle();
  endtask

  task automatic t_unmapped();
    logic [15:0] v;
    wrReg(16'h0206, 16'hD000);
    check("R2 offset 6 no effect", memWe, 0);
    wrReg(16'h0100, 16'hC000);
    check("R2 below base no effect", memWe, 0);
    rdReg(16'h0206, v); check("R2 unmapped read", v, 16'h0000);
    rdReg(A_DHI, v); check("R11 data reg reads zero", v, 16'h0000);
    rdReg(A_AHI, v); check("R11 addr reg reads zero", v, 16'h0000);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    rstN = 1'b0; regAddr = '0; regWrData = '0; regWr = 1'b0; regRd = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_stream();
    t_clear();
    t_execOnly();
    t_busyIgnore();
    t_unmapped();
    summary();
  end
endmodule